// File: doc/BRIEF.md
# Multi-Lane Double-Data-Rate Word Serializer

This block converts parallel pixel words into bit streams on up to four serial data lanes, with a separate forwarded clock lane for the receiver. Each active lane carries its own word. A single bit-rate clock drives the design, and each tick of that clock is one unit interval (UI). The forwarded clock runs at half the bit rate and changes level once per UI, so every clock edge, rising or falling, carries one bit.

Data changes on the rising edge of the bit clock. The forwarded clock changes on the falling edge, which puts each forwarded-clock edge in the middle of its bit and gives the receiver half a UI of setup and half a UI of hold. A valid/ready handshake loads one word per lane. The lane count and word length are captured when a word is accepted, so changing them while a word is in flight only affects the next word. Words sent one after another have no gap between them.

Top module: `ddr_lane_serializer`

## Requirements
- R1: There are four data lanes and one forwarded clock lane. Lane k sends the word held in `in_data[k*20 +: 20]`, right-aligned.
- R2: `lane_sel` sets the number of active lanes. Value 0 gives 2 lanes, 1 gives 3 lanes, and 2 or 3 gives 4 lanes, always the lowest-numbered lanes. An inactive lane outputs 0 at all times.
- R3: `word_len` sets the word length in bits. Values below 12 are treated as 12 and values above 20 as 20. Only the low `word_len` bits of each lane word are sent.
- R4: Bits are sent most significant first. In UI j after the accepting edge (j = 0 is the cycle right after that edge), a lane outputs bit `len-1-j` of its word, so the last UI carries bit 0.
- R5: `in_ready` is 1 when `link_en` is 1 and either no word is in flight or the current UI is the last one of the word. A word accepted in that last UI starts in the very next UI, with no gap.
- R6: The lane count and word length are captured when a word is accepted. Changing `lane_sel` or `word_len` while a word is in flight has no effect on that word.
- R7: While `link_en` is 1, `fwd_clk` changes level on every falling edge of `clk`, so its edges fall in the middle of each UI. While `link_en` is 0, `fwd_clk` is held low.
- R8: When `link_en` is 0, no word is accepted and any word in flight is dropped: from the next rising edge all lanes output 0. The dropped word does not resume when `link_en` returns to 1.
- R9: After reset, all lanes and `fwd_clk` are 0 and no word is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one period per UI |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Enables the forwarded clock and word transfer |
| lane_sel | input | 2 | Active lane count setting |
| word_len | input | 5 | Word length in bits (12 to 20) |
| in_valid | input | 1 | A set of lane words is offered |
| in_ready | output | 1 | A set of lane words can be accepted this cycle |
| in_data | input | 80 | Lane words, 20 bits per lane, lane 0 in the low bits |
| lane_out | output | 4 | Serial data, one bit per lane |
| fwd_clk | output | 1 | Forwarded half-rate clock |

## Verification
Some properties are checked by assertions on every cycle:
- inactive lanes stay at 0;
- the bit counter stays within the captured length and counts down by one per UI;
- ready stays low before the last UI of a word;
- the forwarded clock toggles on each falling edge, or holds low when disabled;
- a disabled link leaves nothing in flight.

Other behaviours can only be shown by the bench's sweep of every lane setting and every length from 11 to 21, including the clamped values. These are the actual bit order on each lane, the lane-to-word mapping, gap-free transfer of back-to-back words, a settings change made mid-word that must not alter that word, and a dropped word that must not resume.

// File: rtl/ddr_lane_serializer.sv
module ddr_lane_serializer #(
  parameter int LANES = 4,
  parameter int MAXW  = 20,
  parameter int MINW  = 12,
  parameter int CW    = $clog2(MAXW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_en,
  input  logic [1:0]            lane_sel,
  input  logic [CW-1:0]         word_len,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*MAXW-1:0] in_data,
  output logic [LANES-1:0]      lane_out,
  output logic                  fwd_clk
);

  logic [LANES-1:0][MAXW-1:0] sh;
  logic [CW-1:0]              cnt, len_q, len_eff;
  logic [LANES-1:0]           act_q, cfg_mask;
  logic                       busy, last, accept;

  assign len_eff = (word_len < CW'(MINW)) ? CW'(MINW) :
                   (word_len > CW'(MAXW)) ? CW'(MAXW) : word_len;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign cfg_mask[k] = (int'(lane_sel) + 2) > k;
    assign lane_out[k] = busy & act_q[k] & sh[k][MAXW-1];
  end

  assign last     = busy && (cnt == '0);
  assign in_ready = link_en && (!busy || last);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= CW'(MINW);
      act_q <= '0;
    end else if (!link_en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= len_eff - CW'(1);
      len_q <= len_eff;
      act_q <= cfg_mask;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (accept)    sh[k] <= in_data[k*MAXW +: MAXW] << (CW'(MAXW) - len_eff);
        else if (busy) sh[k] <= sh[k] << 1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       fwd_clk <= 1'b0;
    else if (link_en) fwd_clk <= ~fwd_clk;
    else              fwd_clk <= 1'b0;
  end

  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out & ~act_q) == '0); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && busy && cnt != '0) |=> (busy && cnt == $past(cnt) - CW'(1))); // R4
  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |-> !in_ready); // R5
  AST_FWD_TOGGLE: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(link_en)) |-> (fwd_clk != $past(fwd_clk))); // R7
  AST_FWD_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(link_en)) |-> !fwd_clk); // R7
  AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> (lane_out == '0)); // R8

endmodule

// File: tb/test_ddr_lane_serializer.sv
module test_ddr_lane_serializer;
  logic        clk = 1'b0, rst_n = 1'b0, link_en = 1'b0, in_valid = 1'b0;
  logic [1:0]  lane_sel = '0;
  logic [4:0]  word_len = 5'd12;
  logic [79:0] in_data = '0;
  logic        in_ready, fwd_clk;
  logic [3:0]  lane_out;
  int checks = 0, errors = 0;
  logic last_fwd;

  always #5 clk = ~clk;

  ddr_lane_serializer i_ddr_lane_serializer (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .lane_sel(lane_sel),
    .word_len(word_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lane_out(lane_out), .fwd_clk(fwd_clk));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [79:0] mk(input int s);
    logic [31:0] a, b, c;
    a = 32'h9E3779B9 * (s + 1);
    b = 32'h7F4A7C15 ^ (a << 3);
    c = a + 32'h01234567 * s;
    return {a[15:0], b, c};
  endfunction

  function automatic logic [3:0] expect_bits(input logic [79:0] d, input int sel, input int len, input int j);
    int n, L;
    logic [3:0] r;
    n = (sel == 0) ? 2 : (sel == 1) ? 3 : 4;
    L = (len < 12) ? 12 : (len > 20) ? 20 : len;
    for (int k = 0; k < 4; k++) r[k] = (k < n) ? d[k*20 + L - 1 - j] : 1'b0;
    return r;
  endfunction

  task automatic run_stream(input int sel, input int len);
    logic [79:0] d0, d1;
    int L;
    L = (len < 12) ? 12 : (len > 20) ? 20 : len;
    d0 = mk(sel * 37 + len);
    d1 = mk(sel * 41 + len + 500);
    lane_sel = 2'(sel); word_len = 5'(len); in_data = d0; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R5 ready when idle", in_ready, 1);
    last_fwd = fwd_clk;
    @(posedge clk);
    for (int w = 0; w < 2; w++) begin
      for (int j = 0; j < L; j++) begin
        #1;
        if (j == 0 && w == 0) in_data = d1;
        if (j == 0 && w == 1) begin
          in_valid = 1'b0;
          lane_sel = 2'(sel ^ 1);
          word_len = 5'((len > 15) ? 12 : 20);
        end
        chk(lane_out == expect_bits(w == 0 ? d0 : d1, sel, len, j),
            (w == 0) ? "R1 R2 R3 R4 lane bits" : "R1 R2 R4 R6 second word bits",
            lane_out, expect_bits(w == 0 ? d0 : d1, sel, len, j));
        chk(in_ready == (j == L - 1), "R5 ready in last UI only", in_ready, int'(j == L - 1));
        chk(fwd_clk != last_fwd, "R7 fwd_clk toggles each UI", fwd_clk, !last_fwd);
        last_fwd = fwd_clk;
        @(posedge clk);
      end
    end
    #1;
    chk(lane_out == 4'b0, "R2 lanes idle after stream", lane_out, 0);
    chk(in_ready == 1'b1, "R5 ready idle after stream", in_ready, 1);
  endtask

  initial begin
    logic f;
    #2;
    chk(lane_out == 4'b0, "R9 lanes zero in reset", lane_out, 0);
    chk(fwd_clk == 1'b0, "R9 fwd_clk low in reset", fwd_clk, 0);
    chk(in_ready == 1'b0, "R9 not ready in reset", in_ready, 0);
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(lane_out == 4'b0, "R9 lanes zero after reset", lane_out, 0);
    chk(fwd_clk == 1'b0, "R7 fwd_clk low while disabled", fwd_clk, 0);
    chk(in_ready == 1'b0, "R8 no ready while disabled", in_ready, 0);
    link_en = 1'b1;
    @(posedge clk); #1;
    f = fwd_clk;
    #5;
    chk(fwd_clk != f, "R7 fwd_clk edge mid UI", fwd_clk, !f);
    @(posedge clk); #1;
    for (int s = 0; s < 4; s++)
      for (int l = 11; l <= 21; l++)
        run_stream(s, l);
    in_data = mk(999); lane_sel = 2'd2; word_len = 5'd16; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(lane_out == expect_bits(mk(999), 2, 16, 0), "R4 first bit before drop", lane_out, expect_bits(mk(999), 2, 16, 0));
    @(posedge clk); @(posedge clk); #1;
    link_en = 1'b0;
    @(posedge clk); #1;
    chk(lane_out == 4'b0, "R8 lanes zero after drop", lane_out, 0);
    chk(in_ready == 1'b0, "R8 no ready while disabled", in_ready, 0);
    #5;
    chk(fwd_clk == 1'b0, "R7 fwd_clk held low", fwd_clk, 0);
    @(posedge clk); #1;
    link_en = 1'b1;
    @(posedge clk); #1;
    chk(lane_out == 4'b0, "R8 dropped word not resumed", lane_out, 0);
    chk(in_ready == 1'b1, "R8 ready again when enabled", in_ready, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule